// File: doc/BRIEF.md
# Serial Transceiver Bring-Up Sequencer

This block walks a multi-gigabit serial transceiver, used as the physical layer of a storage link, through its power-up. While the external reference clock source is being reprogrammed, the transceiver is kept in its deepest power-down state. Once the clock is reported stable, the block powers the transceiver on and waits for the channel PLL to lock. It then releases the transmit and receive resets and waits for both reset-done indications. Only after that does it tell the link layer that the physical layer is ready.

All four status inputs are asynchronous. Each one passes through a two-flop synchronizer, and the outputs are registered. Every waiting phase has a watchdog. If a phase overruns its limit, the sequencer drops back to power-down and raises a sticky error. The nominal reference clock is 150 MHz. The default limits are four times the typical lock time (about 6180 cycles), four times the transmit-done time (about 270 cycles) and four times the receive-done time (about 1760 cycles).

Top module: `xcvr_bringup_seq`

## Requirements
- R1: While `refClkStable` is low, `pwrDownCode` is 2'b11 (full power-down) and both resets are high. This holds whatever the other inputs do.
- R2: `pwrDownCode` changes to 2'b00 (powered on) only after `refClkStable` rises. The change appears on the 4th rising clock edge after the input changes: two synchronizer flops, the state register and the output register.
- R3: `txReset` and `rxReset` stay high until `pllLock` is seen. They fall on the 4th edge after `pllLock` rises.
- R4: Transmit and receive completion are tracked separately. `linkReady` stays low while only `txResetDone` is high.
- R5: `linkReady` rises on the 4th edge after the second of the two reset-done inputs goes high, as long as both are high.
- R6: If `pllLock` falls while ready, `linkReady` falls on the 3rd edge. On the 4th edge both resets are asserted again, and `pwrDownCode` stays 2'b00 (the sequence restarts at the wait-for-lock phase).
- R7: If lock does not arrive within `LOCK_LIMIT` cycles of entering the lock phase, the sequencer returns to power-down and sets `seqError`.
- R8: After the resets are released, a missing `txResetDone` after `TX_LIMIT` cycles or a missing `rxResetDone` after `RX_LIMIT` cycles returns the sequencer to power-down and sets `seqError`.
- R9: `seqError` is sticky. It stays high through later retries and a successful bring-up until `rst`.
- R10: If `refClkStable` falls in any powered phase, `linkReady` falls on the 3rd edge. On the 4th edge `pwrDownCode` returns to 2'b11 with both resets high.
- R11: A synchronous active-high `rst` sets `pwrDownCode` to 2'b11, both resets high, `linkReady` low and `seqError` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference-domain clock |
| rst | input | 1 | Synchronous active-high reset |
| refClkStable | input | 1 | Reference clock reported stable (asynchronous) |
| pllLock | input | 1 | Channel PLL locked (asynchronous) |
| txResetDone | input | 1 | Transmit reset completed (asynchronous) |
| rxResetDone | input | 1 | Receive reset completed (asynchronous) |
| pwrDownCode | output | 2 | Transceiver power state: 2'b11 off, 2'b00 on |
| txReset | output | 1 | Transmit reset, active high |
| rxReset | output | 1 | Receive reset, active high |
| linkReady | output | 1 | Physical layer ready for the link layer |
| seqError | output | 1 | Sticky watchdog-timeout flag |

## Verification
The main sequence is driven in order: clock stable, then lock, then transmit done alone, then receive done. Exact-edge checks on this run separate the synchronizer and register latency from an off-by-one stage. Holding lock and both done inputs high while the clock is unstable shows that power-down outranks later phases. Dropping lock, and separately the clock, from the ready state shows that the two exits land in different phases. Three timeout patterns, each withholding one of lock, transmit done or receive done, show that each watchdog uses its own limit and that the error survives a later successful bring-up.

// File: rtl/xbs_pkg.sv
package xbs_pkg;

  // Power state codes driven to the transceiver
  localparam logic [1:0] PWR_ON  = 2'b00;
  localparam logic [1:0] PWR_OFF = 2'b11;

  typedef enum logic [1:0] {
    ST_OFF  = 2'd0,   // held in full power-down
    ST_LOCK = 2'd1,   // powered, waiting for PLL lock
    ST_DONE = 2'd2,   // resets released, waiting for both done flags
    ST_LIVE = 2'd3    // link ready
  } seqState_t;

  // Synchronized status inputs
  typedef struct packed {
    logic stable;
    logic lock;
    logic txDone;
    logic rxDone;
  } syncIn_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic clrPhase;
    logic setErr;
    logic powerUp;
    logic releaseRst;
    logic ready;
  } ctlStrobe_t;

  // Status from datapath to control
  typedef struct packed {
    logic lockTo;
    logic txTo;
    logic rxTo;
    logic txSeen;
    logic rxSeen;
  } dpStatus_t;

endpackage

// File: rtl/xbs_sync.sv
module xbs_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [STAGES-1:0][WIDTH-1:0] chain;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= '0;
          else     chain[0] <= asyncIn;
        end
      end else begin : g_rest
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= '0;
          else     chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign syncOut = chain[STAGES-1];

endmodule

// File: rtl/xbs_datapath.sv
module xbs_datapath
  import xbs_pkg::*;
#(
  parameter int LOCK_LIMIT = 24720,
  parameter int TX_LIMIT   = 1080,
  parameter int RX_LIMIT   = 7040
) (
  input  logic       clk,
  input  logic       rst,
  input  ctlStrobe_t ctl,
  input  logic       syncTxDone,
  input  logic       syncRxDone,
  output dpStatus_t  st,
  output logic [1:0] pwrDownCode,
  output logic       txReset,
  output logic       rxReset,
  output logic       linkReady,
  output logic       seqError
);

  localparam int MAX_AB    = (LOCK_LIMIT > TX_LIMIT) ? LOCK_LIMIT : TX_LIMIT;
  localparam int MAX_LIMIT = (MAX_AB > RX_LIMIT) ? MAX_AB : RX_LIMIT;
  localparam int CNT_W     = $clog2(MAX_LIMIT + 1);
  localparam logic [CNT_W-1:0] CNT_TOP  = CNT_W'(MAX_LIMIT);
  localparam logic [CNT_W-1:0] LOCK_CMP = CNT_W'(LOCK_LIMIT);
  localparam logic [CNT_W-1:0] TX_CMP   = CNT_W'(TX_LIMIT);
  localparam logic [CNT_W-1:0] RX_CMP   = CNT_W'(RX_LIMIT);

  logic [CNT_W-1:0] phaseCnt;
  logic             txSeenQ;
  logic             rxSeenQ;

  // Phase watchdog counter, saturating at the largest limit
  always_ff @(posedge clk) begin
    if (rst || ctl.clrPhase)    phaseCnt <= '0;
    else if (phaseCnt < CNT_TOP) phaseCnt <= phaseCnt + 1'b1;
  end

  // Independent completion tracking for each direction
  always_ff @(posedge clk) begin
    if (rst || ctl.clrPhase) begin
      txSeenQ <= 1'b0;
      rxSeenQ <= 1'b0;
    end else if (ctl.releaseRst) begin
      if (syncTxDone) txSeenQ <= 1'b1;
      if (syncRxDone) rxSeenQ <= 1'b1;
    end
  end

  assign st.lockTo = (phaseCnt >= LOCK_CMP);
  assign st.txTo   = (phaseCnt >= TX_CMP);
  assign st.rxTo   = (phaseCnt >= RX_CMP);
  assign st.txSeen = txSeenQ;
  assign st.rxSeen = rxSeenQ;

  // Registered outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      pwrDownCode <= PWR_OFF;
      txReset     <= 1'b1;
      rxReset     <= 1'b1;
      linkReady   <= 1'b0;
      seqError    <= 1'b0;
    end else begin
      pwrDownCode <= ctl.powerUp ? PWR_ON : PWR_OFF;
      txReset     <= ~ctl.releaseRst;
      rxReset     <= ~ctl.releaseRst;
      linkReady   <= ctl.ready;
      if (ctl.setErr) seqError <= 1'b1;
    end
  end

endmodule

// File: rtl/xbs_ctrl.sv
module xbs_ctrl
  import xbs_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  syncIn_t    sIn,
  input  dpStatus_t  st,
  output ctlStrobe_t ctl
);

  seqState_t state;
  seqState_t nxt;
  logic      setErr;
  logic      txOk;
  logic      rxOk;

  assign txOk = st.txSeen | sIn.txDone;
  assign rxOk = st.rxSeen | sIn.rxDone;

  always_comb begin
    nxt    = state;
    setErr = 1'b0;
    case (state)
      ST_OFF: begin
        if (sIn.stable) nxt = ST_LOCK;
      end
      ST_LOCK: begin
        if (!sIn.stable)   nxt = ST_OFF;
        else if (sIn.lock) nxt = ST_DONE;
        else if (st.lockTo) begin
          nxt    = ST_OFF;
          setErr = 1'b1;
        end
      end
      ST_DONE: begin
        if (!sIn.stable)      nxt = ST_OFF;
        else if (!sIn.lock)   nxt = ST_LOCK;
        else if (txOk && rxOk) nxt = ST_LIVE;
        else if ((st.txTo && !txOk) || (st.rxTo && !rxOk)) begin
          nxt    = ST_OFF;
          setErr = 1'b1;
        end
      end
      ST_LIVE: begin
        if (!sIn.stable)                     nxt = ST_OFF;
        else if (!sIn.lock)                  nxt = ST_LOCK;
        else if (!(sIn.txDone && sIn.rxDone)) nxt = ST_DONE;
      end
      default: nxt = ST_OFF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_OFF;
    else     state <= nxt;
  end

  assign ctl.clrPhase   = (nxt != state);
  assign ctl.setErr     = setErr;
  assign ctl.powerUp    = (state != ST_OFF);
  assign ctl.releaseRst = (state == ST_DONE) || (state == ST_LIVE);
  assign ctl.ready      = (state == ST_LIVE) && sIn.stable && sIn.lock &&
                          sIn.txDone && sIn.rxDone;

endmodule

// File: rtl/xcvr_bringup_seq.sv
module xcvr_bringup_seq
  import xbs_pkg::*;
#(
  parameter int LOCK_LIMIT = 24720,
  parameter int TX_LIMIT   = 1080,
  parameter int RX_LIMIT   = 7040
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       refClkStable,
  input  logic       pllLock,
  input  logic       txResetDone,
  input  logic       rxResetDone,
  output logic [1:0] pwrDownCode,
  output logic       txReset,
  output logic       rxReset,
  output logic       linkReady,
  output logic       seqError
);

  logic [3:0] syncBits;
  syncIn_t    sIn;
  ctlStrobe_t ctl;
  dpStatus_t  st;

  xbs_sync #(.WIDTH(4), .STAGES(2)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .asyncIn ({refClkStable, pllLock, txResetDone, rxResetDone}),
    .syncOut (syncBits)
  );

  assign sIn = syncIn_t'(syncBits);

  xbs_ctrl u_ctrl (
    .clk (clk),
    .rst (rst),
    .sIn (sIn),
    .st  (st),
    .ctl (ctl)
  );

  xbs_datapath #(
    .LOCK_LIMIT (LOCK_LIMIT),
    .TX_LIMIT   (TX_LIMIT),
    .RX_LIMIT   (RX_LIMIT)
  ) u_dp (
    .clk         (clk),
    .rst         (rst),
    .ctl         (ctl),
    .syncTxDone  (sIn.txDone),
    .syncRxDone  (sIn.rxDone),
    .st          (st),
    .pwrDownCode (pwrDownCode),
    .txReset     (txReset),
    .rxReset     (rxReset),
    .linkReady   (linkReady),
    .seqError    (seqError)
  );

endmodule

// File: rtl/xbs_chk.sv
module xbs_chk (
  input logic       clk,
  input logic       rst,
  input logic       refClkStable,
  input logic       pllLock,
  input logic [1:0] pwrDownCode,
  input logic       txReset,
  input logic       rxReset,
  input logic       linkReady,
  input logic       seqError
);

  // R1
  off_holds_resets_chk: assert property (@(posedge clk) disable iff (rst)
    (pwrDownCode == 2'b11) |-> (txReset && rxReset));

  // R3
  release_needs_power_chk: assert property (@(posedge clk) disable iff (rst)
    (!txReset || !rxReset) |-> (pwrDownCode == 2'b00));

  // R5
  ready_needs_release_chk: assert property (@(posedge clk) disable iff (rst)
    linkReady |-> (!txReset && !rxReset));

  // R6
  ready_needs_lock_chk: assert property (@(posedge clk) disable iff (rst)
    linkReady |-> ($past(pllLock, 3) && $past(refClkStable, 3)));

  // R2
  power_needs_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (pwrDownCode == 2'b00) |-> $past(refClkStable, 4));

  // R9
  error_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    seqError |=> seqError);

endmodule

bind xcvr_bringup_seq xbs_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .refClkStable (refClkStable),
  .pllLock      (pllLock),
  .pwrDownCode  (pwrDownCode),
  .txReset      (txReset),
  .rxReset      (rxReset),
  .linkReady    (linkReady),
  .seqError     (seqError)
);

// File: tb/xcvr_bringup_seq_bench.sv
`timescale 1ns/1ps
module xcvr_bringup_seq_bench;

  localparam logic [1:0] P_ON  = 2'b00;
  localparam logic [1:0] P_OFF = 2'b11;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       refClkStable = 1'b0;
  logic       pllLock = 1'b0;
  logic       txResetDone = 1'b0;
  logic       rxResetDone = 1'b0;
  logic [1:0] pwrDownCode;
  logic       txReset;
  logic       rxReset;
  logic       linkReady;
  logic       seqError;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct {
    logic [1:0] pwr;
    logic       txr;
    logic       rxr;
    logic       rdy;
    logic       err;
    logic [4:0] mask;
    string      req;
  } exp_t;

  exp_t expQ[$];

  always #2 clk = ~clk;   // 250 MHz

  xcvr_bringup_seq #(
    .LOCK_LIMIT (40),
    .TX_LIMIT   (20),
    .RX_LIMIT   (30)
  ) u_xcvr_bringup_seq (
    .clk          (clk),
    .rst          (rst),
    .refClkStable (refClkStable),
    .pllLock      (pllLock),
    .txResetDone  (txResetDone),
    .rxResetDone  (rxResetDone),
    .pwrDownCode  (pwrDownCode),
    .txReset      (txReset),
    .rxReset      (rxReset),
    .linkReady    (linkReady),
    .seqError     (seqError)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expectAll(input logic [1:0] p, input logic t, input logic r,
                           input logic y, input logic e, input string req);
    exp_t it;
    it.pwr = p; it.txr = t; it.rxr = r; it.rdy = y; it.err = e;
    it.mask = 5'b11111; it.req = req;
    expQ.push_back(it);
  endtask

  task automatic expectErr(input logic e, input string req);
    exp_t it;
    it.pwr = 2'b00; it.txr = 1'b0; it.rxr = 1'b0; it.rdy = 1'b0; it.err = e;
    it.mask = 5'b00001; it.req = req;
    expQ.push_back(it);
  endtask

  // Monitor: compares queued expectations just after the driving negedge
  always begin
    exp_t e;
    logic [5:0] act;
    logic [5:0] exv;
    logic [5:0] m;
    @(negedge clk);
    #1;
    while (expQ.size() > 0) begin
      e   = expQ.pop_front();
      act = {pwrDownCode, txReset, rxReset, linkReady, seqError};
      exv = {e.pwr, e.txr, e.rxr, e.rdy, e.err};
      m   = {e.mask[4], e.mask[4], e.mask[3:0]};
      checks++;
      if ((act & m) !== (exv & m)) begin
        fails++;
        $display("FAIL %s: actual pwr/txr/rxr/rdy/err=%b expected=%b (mask %b)",
                 e.req, act, exv, m);
      end
    end
  end

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    step(3);
    expectAll(P_OFF, 1, 1, 0, 0, "R11 reset state");
    rst = 1'b0;
    step(10);
    expectAll(P_OFF, 1, 1, 0, 0, "R1 off while clock unstable");

    // Main bring-up
    refClkStable = 1'b1;
    step(3);
    expectAll(P_OFF, 1, 1, 0, 0, "R2 still off before latency");
    step(1);
    expectAll(P_ON, 1, 1, 0, 0, "R2 powered on 4th edge");
    step(10);
    expectAll(P_ON, 1, 1, 0, 0, "R3 resets held without lock");
    pllLock = 1'b1;
    step(3);
    expectAll(P_ON, 1, 1, 0, 0, "R3 resets before latency");
    step(1);
    expectAll(P_ON, 0, 0, 0, 0, "R3 resets released 4th edge");
    txResetDone = 1'b1;
    step(10);
    expectAll(P_ON, 0, 0, 0, 0, "R4 tx done alone not ready");
    rxResetDone = 1'b1;
    step(3);
    expectAll(P_ON, 0, 0, 0, 0, "R5 ready before latency");
    step(1);
    expectAll(P_ON, 0, 0, 1, 0, "R5 ready on 4th edge");
    step(5);

    // Lock loss
    pllLock = 1'b0;
    step(2);
    expectAll(P_ON, 0, 0, 1, 0, "R6 ready before latency");
    step(1);
    expectAll(P_ON, 0, 0, 0, 0, "R6 ready dropped 3rd edge");
    step(1);
    expectAll(P_ON, 1, 1, 0, 0, "R6 resets reasserted, power kept");

    // Lock watchdog (lock phase entered on 3rd edge)
    step(39);
    expectAll(P_ON, 1, 1, 0, 0, "R7 no error before limit");
    step(1);
    expectAll(P_ON, 1, 1, 0, 1, "R7 error at limit");
    step(1);
    expectAll(P_OFF, 1, 1, 0, 1, "R7 back to power-down");
    step(1);
    expectAll(P_ON, 1, 1, 0, 1, "R9 retry keeps error");
    pllLock = 1'b1;
    step(12);
    expectAll(P_ON, 0, 0, 1, 1, "R9 error sticky after success");

    // Clock loss
    refClkStable = 1'b0;
    step(3);
    expectAll(P_ON, 0, 0, 0, 1, "R10 ready dropped 3rd edge");
    step(1);
    expectAll(P_OFF, 1, 1, 0, 1, "R10 power-down 4th edge");

    rst = 1'b1;
    step(1);
    expectAll(P_OFF, 1, 1, 0, 0, "R11 reset clears error");
    rst = 1'b0;
    step(10);
    expectAll(P_OFF, 1, 1, 0, 0, "R1 off despite lock and done");

    // RX watchdog
    rxResetDone  = 1'b0;
    refClkStable = 1'b1;
    step(34);
    expectAll(P_ON, 0, 0, 0, 0, "R8 rx no error before limit");
    step(1);
    expectErr(1, "R8 rx watchdog error");

    // TX watchdog
    rst = 1'b1;
    txResetDone = 1'b0;
    rxResetDone = 1'b1;
    step(1);
    expectAll(P_OFF, 1, 1, 0, 0, "R11 reset state again");
    rst = 1'b0;
    step(24);
    expectAll(P_ON, 0, 0, 0, 0, "R8 tx no error before limit");
    step(1);
    expectErr(1, "R8 tx watchdog error");

    step(3);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule